// File: doc/BRIEF.md
# Streaming Random-Bit Health Tester

This block watches a serial stream of random bits and judges each block of 20,000 accepted bits against four statistical checks. The checks are a ones-count window, a 4-bit poker test, a run-length distribution test and a long-run test. It is meant to sit beside an entropy source. Software or a control unit pulses `start`, the generator feeds one bit per `bitValid` strobe, and when the block is complete the tester raises `done` for one cycle. At that point the four per-test flags and their conjunction are valid.

All arithmetic is integer. The poker statistic is normally written with a fraction. Here both sides of the acceptance window are scaled by 5000, so the test becomes a comparison of sixteen times the sum of squared nibble counts against two integer limits. The sum of squares is built one step at a time as nibbles arrive, so no multiplier or divider is needed. Runs are tallied while the bits stream through, and the last run is closed on the final bit of the block.

Top module: `rng_health_tester`

## Requirements
- R1: After `start`, exactly 20,000 bits are taken, one on each cycle where `bitValid` is 1. In the cycle after the 20,000th bit, `busy` is still 1. On the next clock edge `done` and the result flags update and `busy` drops to 0.
- R2: `onesPass` is 1 only when the number of ones in the block is strictly greater than 9,654 and strictly less than 10,346.
- R3: The block is cut into 5,000 non-overlapping 4-bit groups, with the first bit of a group as its most significant bit. With S the sum of the squared occurrence counts of the 16 values, `pokerPass` is 1 only when 25,005,150 < 16·S < 25,287,000.
- R4: Runs of ones and runs of zeros are tallied separately by length: 1, 2, 3, 4, 5 and 6-or-more. `runsPass` is 1 only when every one of the 12 tallies lies inside its inclusive window: 2267–2733, 1079–1421, 502–748, 223–402, 90–223 and 90–223, for those lengths in that order.
- R5: `longRunPass` is 0 when any run of identical bits is longer than 33. A run of exactly 33 passes. The run still open when the 20,000th bit arrives is counted in both this check and the R4 tallies.
- R6: `overallPass` is 1 exactly when all four per-test flags are 1.
- R7: `done` is high for exactly one cycle per completed block. The result flags keep their values until the next `start`, and reset clears them and `done` to 0.
- R8: A `start` pulse clears every count and every result flag, and begins a fresh block even in the middle of one.
- R9: Bits offered while the tester is idle, and bits on cycles where `bitValid` is 0, have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears all counts and begins a new block |
| bitIn | input | 1 | Serial random bit |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| busy | output | 1 | A block is being collected or evaluated |
| done | output | 1 | One-cycle pulse when the results become valid |
| onesPass | output | 1 | Ones-count test result |
| pokerPass | output | 1 | Poker test result |
| runsPass | output | 1 | Run-length distribution test result |
| longRunPass | output | 1 | Long-run test result |
| overallPass | output | 1 | All four tests passed |

## Verification
Some properties are checked on every cycle by the assertions:
- `done` never lasts longer than one cycle and only appears with `busy` low.
- `busy` only falls together with `done`.
- The result flags stay frozen between evaluations.
- The open run length is never zero once a run exists.
- The long-run mark, once set, stays set.
- The sum of squares strictly grows with each completed nibble.

Whether the statistics are right can only be shown by the bench's scenarios. Those compare every cycle against a behavioural model fed with:
- a pseudo-random block with gaps in `bitValid`;
- an all-ones block;
- blocks with a 34-bit run and with exactly a 33-bit run;
- a repeated 4-bit pattern;
- a restart in the middle of a block.

// File: rtl/rng_hlth_pkg.sv
package rng_hlth_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic clear;     // start of a new block: wipe every count and result
    logic sample;    // bitIn is accepted this cycle
    logic last;      // the accepted bit is the final bit of the block
    logic evaluate;  // counts are final: latch the verdicts
  } ctrlStrobes_t;

  localparam int NUM_BUCKETS = 6;

  // Inclusive lower limit of a run-length tally; bucket 5 means length >= 6
  function automatic int runWinLo(int bucket);
    case (bucket)
      0:       return 2267;
      1:       return 1079;
      2:       return 502;
      3:       return 223;
      default: return 90;
    endcase
  endfunction

  // Inclusive upper limit of a run-length tally
  function automatic int runWinHi(int bucket);
    case (bucket)
      0:       return 2733;
      1:       return 1421;
      2:       return 748;
      3:       return 402;
      default: return 223;
    endcase
  endfunction

endpackage

// File: rtl/rng_hlth_ctrl.sv
module rng_hlth_ctrl
  import rng_hlth_pkg::*;
#(
  parameter int BLOCK_BITS = 20000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         bitValid,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  localparam int CNT_W = $clog2(BLOCK_BITS);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EVAL    = 2'd2
  } ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             atLast;

  assign atLast           = (bitCnt == CNT_W'(BLOCK_BITS - 1));
  assign strobes.clear    = start;
  assign strobes.sample   = (state == ST_COLLECT) && bitValid && !start;
  assign strobes.last     = strobes.sample && atLast;
  assign strobes.evaluate = (state == ST_EVAL) && !start;
  assign busy             = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state  <= ST_COLLECT;
        bitCnt <= '0;
      end else begin
        case (state)
          ST_COLLECT: begin
            if (strobes.sample) begin
              if (atLast) state <= ST_EVAL;
              else        bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_EVAL: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R1
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COLLECT) |-> (bitCnt < CNT_W'(BLOCK_BITS - 1)) || atLast);

endmodule

// File: rtl/rng_hlth_datapath.sv
module rng_hlth_datapath
  import rng_hlth_pkg::*;
#(
  parameter int BLOCK_BITS = 20000,
  parameter int ONES_LO    = 9654,
  parameter int ONES_HI    = 10346,
  parameter int POKER_LO   = 25005150,
  parameter int POKER_HI   = 25287000,
  parameter int LONG_MAX   = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  input  logic         bitIn,
  output logic         onesPass,
  output logic         pokerPass,
  output logic         runsPass,
  output logic         longRunPass,
  output logic         overallPass
);

  localparam int CNT_W   = $clog2(BLOCK_BITS + 1);
  localparam int SEG     = BLOCK_BITS / 4;
  localparam int SEG_W   = $clog2(SEG + 1);
  localparam int ACC_W   = 2 * SEG_W;
  localparam int SCALE_W = ACC_W + 4;
  localparam int RUN_W   = $clog2(LONG_MAX + 2);
  localparam int NTALLY  = 2 * NUM_BUCKETS;

  logic clear, sample, last, evaluate;
  assign clear    = strobes.clear;
  assign sample   = strobes.sample;
  assign last     = strobes.last;
  assign evaluate = strobes.evaluate;

  // ---------------- ones count ----------------
  logic [CNT_W-1:0] onesCnt;
  always_ff @(posedge clk) begin
    if (rst || clear)          onesCnt <= '0;
    else if (sample && bitIn)  onesCnt <= onesCnt + 1'b1;
  end

  // ---------------- poker ----------------
  logic [2:0]       nib;
  logic [1:0]       phase;
  logic             segDone;
  logic [3:0]       segVal;
  logic [SEG_W-1:0] pokerCnt [16];
  logic [SEG_W-1:0] segCntSel;
  logic [ACC_W-1:0] sqSum;

  assign segDone   = sample && (phase == 2'd3);
  assign segVal    = {nib, bitIn};
  assign segCntSel = pokerCnt[segVal];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      nib   <= '0;
      phase <= '0;
    end else if (sample) begin
      nib   <= {nib[1:0], bitIn};
      phase <= phase + 1'b1;
    end
  end

  for (genvar g = 0; g < 16; g++) begin : g_bin
    logic [SEG_W-1:0] binCnt;
    always_ff @(posedge clk) begin
      if (rst || clear)                       binCnt <= '0;
      else if (segDone && segVal == 4'(g))    binCnt <= binCnt + 1'b1;
    end
    assign pokerCnt[g] = binCnt;
  end

  // (f+1)^2 - f^2 = 2f + 1: square sum grows without a multiplier
  always_ff @(posedge clk) begin
    if (rst || clear) sqSum <= '0;
    else if (segDone) sqSum <= sqSum + ACC_W'({segCntSel, 1'b1});
  end

  // ---------------- runs ----------------
  logic             curBit;
  logic [RUN_W-1:0] runLen;
  logic             haveRun;
  logic             longHit;
  logic             sameBit;
  logic [RUN_W-1:0] lenInc, newLen;
  logic             closePrev, closeFinal;
  logic [2:0]       bktPrev, bktFinal;

  function automatic logic [2:0] bucketOf(logic [RUN_W-1:0] len);
    return (len >= RUN_W'(NUM_BUCKETS)) ? 3'(NUM_BUCKETS - 1) : 3'(len - 1'b1);
  endfunction

  assign sameBit    = haveRun && (bitIn == curBit);
  assign lenInc     = (runLen == {RUN_W{1'b1}}) ? runLen : runLen + 1'b1;
  assign newLen     = sameBit ? lenInc : RUN_W'(1);
  assign closePrev  = sample && haveRun && !sameBit;
  assign closeFinal = last;
  assign bktPrev    = bucketOf(runLen);
  assign bktFinal   = bucketOf(newLen);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      curBit  <= 1'b0;
      runLen  <= '0;
      haveRun <= 1'b0;
      longHit <= 1'b0;
    end else if (sample) begin
      curBit  <= bitIn;
      runLen  <= newLen;
      haveRun <= 1'b1;
      if (newLen > RUN_W'(LONG_MAX)) longHit <= 1'b1;
    end
  end

  logic [NTALLY-1:0] inWin;

  for (genvar c = 0; c < 2; c++) begin : g_color
    for (genvar b = 0; b < NUM_BUCKETS; b++) begin : g_bkt
      logic [CNT_W-1:0] tally;
      logic             hit;
      assign hit = (closePrev  && curBit == 1'(c) && bktPrev  == 3'(b)) ||
                   (closeFinal && bitIn  == 1'(c) && bktFinal == 3'(b));
      always_ff @(posedge clk) begin
        if (rst || clear) tally <= '0;
        else if (hit)     tally <= tally + 1'b1;
      end
      assign inWin[c*NUM_BUCKETS + b] = (tally >= CNT_W'(runWinLo(b))) &&
                                        (tally <= CNT_W'(runWinHi(b)));
    end
  end

  // ---------------- verdicts ----------------
  logic                onesOk, pokerOk, runsOk, longOk;
  logic [SCALE_W-1:0]  scaled;

  assign scaled  = {sqSum, 4'b0000};
  assign onesOk  = (onesCnt > CNT_W'(ONES_LO)) && (onesCnt < CNT_W'(ONES_HI));
  assign pokerOk = (scaled > SCALE_W'(POKER_LO)) && (scaled < SCALE_W'(POKER_HI));
  assign runsOk  = &inWin;
  assign longOk  = !longHit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      onesPass    <= 1'b0;
      pokerPass   <= 1'b0;
      runsPass    <= 1'b0;
      longRunPass <= 1'b0;
      overallPass <= 1'b0;
    end else if (evaluate) begin
      onesPass    <= onesOk;
      pokerPass   <= pokerOk;
      runsPass    <= runsOk;
      longRunPass <= longOk;
      overallPass <= onesOk && pokerOk && runsOk && longOk;
    end
  end

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && !evaluate) |=> $stable({onesPass, pokerPass, runsPass, longRunPass, overallPass}));

  // R5
  run_len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    haveRun |-> (runLen != '0));

  // R5
  long_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (longHit && !clear) |=> longHit);

  // R3
  sq_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (segDone && !clear) |=> (sqSum > $past(sqSum)));

endmodule

// File: rtl/rng_health_tester.sv
module rng_health_tester
  import rng_hlth_pkg::*;
#(
  parameter int BLOCK_BITS = 20000,
  parameter int ONES_LO    = 9654,
  parameter int ONES_HI    = 10346,
  parameter int POKER_LO   = 25005150,
  parameter int POKER_HI   = 25287000,
  parameter int LONG_MAX   = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bitIn,
  input  logic bitValid,
  output logic busy,
  output logic done,
  output logic onesPass,
  output logic pokerPass,
  output logic runsPass,
  output logic longRunPass,
  output logic overallPass
);

  ctrlStrobes_t strobes;

  rng_hlth_ctrl #(
    .BLOCK_BITS(BLOCK_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .bitValid (bitValid),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  rng_hlth_datapath #(
    .BLOCK_BITS(BLOCK_BITS),
    .ONES_LO   (ONES_LO),
    .ONES_HI   (ONES_HI),
    .POKER_LO  (POKER_LO),
    .POKER_HI  (POKER_HI),
    .LONG_MAX  (LONG_MAX)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .bitIn       (bitIn),
    .onesPass    (onesPass),
    .pokerPass   (pokerPass),
    .runsPass    (runsPass),
    .longRunPass (longRunPass),
    .overallPass (overallPass)
  );

endmodule

// File: tb/tb_rng_health_tester.sv
module tb_rng_health_tester;

  logic clk = 1'b0;
  logic rst, start, bitIn, bitValid;
  logic busy, done, onesPass, pokerPass, runsPass, longRunPass, overallPass;

  int totalChecks = 0;
  int badChecks   = 0;
  int cycles      = 0;
  string phaseTag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  rng_health_tester dut (
    .clk(clk), .rst(rst), .start(start), .bitIn(bitIn), .bitValid(bitValid),
    .busy(busy), .done(done), .onesPass(onesPass), .pokerPass(pokerPass),
    .runsPass(runsPass), .longRunPass(longRunPass), .overallPass(overallPass)
  );

  // ---------------- behavioural reference model ----------------
  bit   blk[$];
  logic mBusy = 0, mDone = 0, evalPend = 0;
  logic mOnes = 0, mPoker = 0, mRuns = 0, mLong = 0, mAll = 0;

  task automatic judge();
    int ones = 0;
    int f[16];
    longint s = 0;
    int tally[2][7];
    int longest = 0;
    int runLen = 0;
    bit prevB = 0;
    int lo[6] = '{2267, 1079, 502, 223, 90, 90};
    int hi[6] = '{2733, 1421, 748, 402, 223, 223};
    bit rOk = 1;
    foreach (f[i]) f[i] = 0;
    for (int c = 0; c < 2; c++) for (int k = 0; k < 7; k++) tally[c][k] = 0;
    for (int i = 0; i < blk.size(); i++) begin
      if (blk[i]) ones++;
      if (i % 4 == 3) f[{blk[i-3], blk[i-2], blk[i-1], blk[i]}]++;
      if (i > 0 && blk[i] == prevB) runLen++;
      else begin
        if (i > 0) tally[prevB][(runLen > 6) ? 6 : runLen]++;
        runLen = 1;
      end
      if (runLen > longest) longest = runLen;
      prevB = blk[i];
    end
    tally[prevB][(runLen > 6) ? 6 : runLen]++;
    for (int v = 0; v < 16; v++) s += longint'(f[v]) * f[v];
    for (int c = 0; c < 2; c++)
      for (int k = 1; k <= 6; k++)
        if (tally[c][k] < lo[k-1] || tally[c][k] > hi[k-1]) rOk = 0;
    mOnes  = (ones > 9654) && (ones < 10346);
    mPoker = (16 * s > 64'd25005150) && (16 * s < 64'd25287000);
    mRuns  = rOk;
    mLong  = (longest <= 33);
    mAll   = mOnes && mPoker && mRuns && mLong;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mBusy = 0; mDone = 0; evalPend = 0;
      {mOnes, mPoker, mRuns, mLong, mAll} = '0;
      blk.delete();
    end else begin
      mDone = 0;
      if (start) begin
        blk.delete();
        mBusy = 1; evalPend = 0;
        {mOnes, mPoker, mRuns, mLong, mAll} = '0;
      end else if (evalPend) begin
        judge();
        evalPend = 0; mBusy = 0; mDone = 1;
      end else if (mBusy && bitValid) begin
        blk.push_back(bitIn);
        if (blk.size() == 20000) evalPend = 1;
      end
    end
  end

  task automatic check1(string req, logic act, logic exp);
    totalChecks++;
    if (act !== exp) begin
      badChecks++;
      $display("FAIL %s [%s] at cycle %0d: actual=%b expected=%b", req, phaseTag, cycles, act, exp);
    end
  endtask

  // compare against the model every cycle, between clock edges
  always @(negedge clk) begin
    if (!rst) begin
      check1("R1 busy", busy, mBusy);
      check1("R7 done", done, mDone);
      check1("R2 ones", onesPass, mOnes);
      check1("R3 poker", pokerPass, mPoker);
      check1("R4 runs", runsPass, mRuns);
      check1("R5 longrun", longRunPass, mLong);
      check1("R6 overall", overallPass, mAll);
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] rng = 32'h2545F491;
  function automatic logic [31:0] xs(logic [31:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic drive(logic s, logic b, logic v);
    @(negedge clk);
    start = s; bitIn = b; bitValid = v;
  endtask

  function automatic logic patBit(int kind, int i, logic r);
    case (kind)
      1: return 1'b1;                                   // all ones
      2: return (i >= 1000 && i < 1034) ? 1'b1 : r;      // 34-bit run
      3: begin                                          // exactly 33-bit run
        if (i == 499 || i == 533) return 1'b0;
        if (i >= 500 && i < 533) return 1'b1;
        return r;
      end
      4: return (i % 4 == 1 || i % 4 == 2);             // repeated 0110
      default: return r;
    endcase
  endfunction

  task automatic runBlock(int kind, bit gaps, int count);
    drive(1, 0, 0);
    for (int i = 0; i < count; i++) begin
      rng = xs(rng);
      if (gaps && rng[7:6] == 2'b00) drive(0, rng[3], 0);  // R9: invalid cycle
      drive(0, patBit(kind, i, rng[31]), 1);
    end
  endtask

  task automatic idleOffer(int n);
    // R9: valid bits while idle must not disturb held results
    for (int i = 0; i < n; i++) begin
      rng = xs(rng);
      drive(0, rng[0], 1);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  endtask

  initial begin
    rst = 1; start = 0; bitIn = 0; bitValid = 0;
    repeat (3) @(negedge clk);
    phaseTag = "R7 reset";
    check1("R7 reset busy", busy, 1'b0);
    check1("R7 reset done", done, 1'b0);
    check1("R6 reset overall", overallPass, 1'b0);
    rst = 0;

    phaseTag = "R9 random with gaps";  runBlock(0, 1, 20000); idleOffer(8);
    phaseTag = "R2 all ones";          runBlock(1, 0, 20000); idleOffer(8);
    phaseTag = "R5 34-bit run";        runBlock(2, 0, 20000); idleOffer(8);
    phaseTag = "R5 33-bit run";        runBlock(3, 0, 20000); idleOffer(8);
    phaseTag = "R3 repeated nibble";   runBlock(4, 0, 20000); idleOffer(8);
    phaseTag = "R8 restart";           runBlock(0, 0, 5000);
    runBlock(0, 0, 20000); idleOffer(8);
    drive(0, 0, 0);
    drive(0, 0, 0);
    finishRun();
  end

  initial begin
    wait (cycles > 190000);
    badChecks++;
    totalChecks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

endmodule